// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block holds the per-vector state of a nested exception controller: an enable bit, a pending bit, an active bit and a sampled input level for each of a parameterised number of vectors. Vectors 1 to 3 are fixed system vectors with the negative priorities -3, -2 and -1. Every other vector carries an 8-bit programmable priority. From this state the block finds the pending vector that should be serviced next. It computes the group priority of the work already running, folds in the core's global mask bits and base-priority threshold, and tells the core whether a new exception may preempt.

The core drives acknowledge and completion requests. Peripherals drive level lines for the external vectors, starting at vector 16. Software-style set-pending and clear-pending strobes reach every vector. Synchronous exceptions (vectors 3 to 13) that are raised while they are disabled or blocked by the current execution priority are redirected to the hard-fault vector, and a sticky flag records this. If even the hard-fault vector cannot run, a sticky lockup flag is raised. An external source whose level is still high when its handler completes is pended again.

Top module: `prio_nest_arb`

## Requirements
- R1: After reset, `pend_vec_o`, `take_o`, `can_take_o`, `ret_base_o`, `done_err_o`, `forced_o` and `lockup_o` are all 0. Vectors 2, 3, 11, 12, 14 and 15 are enabled and all others are disabled. Programmable priorities are 0.
- R2: `pend_vec_o` is the enabled, pending vector with the numerically lowest priority. On equal priority the lower vector number wins. The value is 0 when nothing qualifies, and the no-exception priority is 256.
- R3: `take_o` is 1 exactly when the winner's priority is below the active group priority. The active group priority is the lowest priority among active vectors (256 if none), ANDed with all-ones shifted left by `grp_i`+1.
- R4: The execution priority is -1 with `fmask_i`, else 0 with `imask_i`, else `basepri_i` ANDed with the group mask when `basepri_i` is nonzero, else 256. It is then limited to at most the active group priority. `can_take_o` is 1 when the execution priority is above the winner's priority.
- R5: A set-pending strobe on a vector in 3..13 pends vector 3 instead, and sets the sticky `forced_o`, when that vector's priority is at or above the execution priority or the vector is disabled. Otherwise it pends the vector itself.
- R6: When such a redirection is needed while the execution priority is negative, nothing is pended and the sticky `lockup_o` is set.
- R7: `ack_i` marks the vector shown on `pend_vec_o` active and clears its pending bit, provided that vector is still pending.
- R8: One cycle after `done_i`, `ret_base_o` is 1 when the named vector was active and fewer than two vectors were active before it was cleared. `done_err_o` is 1 when the named vector was not active. Both outputs are 0 in every other cycle.
- R9: An external vector becomes pending on a rising edge of its level line only, not while the line stays high. Completing it while its line is high pends it again.
- R10: Priority writes to vectors 0 to 3 are ignored, so the fixed vectors keep their negative priorities.
- R11: The decision outputs are registered from the stored state, so they reflect a state change one cycle after the edge that made it.
- R12: A clear-pending strobe removes a pending bit. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_level_i | input | NUM_EXT | Level lines of external vectors 16 and up |
| pend_set_i | input | NUM_VEC | Set-pending strobes, one per vector |
| pend_clr_i | input | NUM_VEC | Clear-pending strobes, one per vector |
| en_set_i | input | NUM_VEC | Enable strobes (vectors 4 and up) |
| en_clr_i | input | NUM_VEC | Disable strobes (vectors 4 and up) |
| prio_we_i | input | 1 | Priority write strobe |
| prio_idx_i | input | VW | Vector whose priority is written |
| prio_val_i | input | 8 | Priority value written |
| grp_i | input | 3 | Group/subpriority split field |
| fmask_i | input | 1 | Fault-mask bit of the core |
| imask_i | input | 1 | Interrupt-mask bit of the core |
| basepri_i | input | 8 | Base-priority threshold, 0 = off |
| ack_i | input | 1 | Core accepts the vector on pend_vec_o |
| done_i | input | 1 | Core completes a handler |
| done_idx_i | input | VW | Vector being completed |
| pend_vec_o | output | VW | Highest-priority pending vector, 0 = none |
| take_o | output | 1 | Pending vector outranks active group priority |
| can_take_o | output | 1 | Execution priority allows preemption |
| ret_base_o | output | 1 | Completion returns to thread level |
| done_err_o | output | 1 | Completion named an inactive vector |
| forced_o | output | 1 | Sticky: a fault was redirected to hard fault |
| lockup_o | output | 1 | Sticky: redirection impossible |

## Verification
The assertions assume that the core acknowledges only in a cycle where `pend_vec_o` is nonzero and that it never acknowledges in two consecutive cycles, because the registered vector number lags the state by one cycle. The stimulus therefore separates every acknowledge by idle cycles. Completion requests name a vector only after its acknowledge has been registered. Mask, group and threshold inputs change only on the falling edge, so each decision is taken from one stable set of values.

// File: rtl/prio_nest_pkg.sv
package prio_nest_pkg;
    typedef logic signed [9:0] prio_t;
    localparam prio_t PRIO_NONE   = 10'sd256;
    localparam int    VEC_RESET   = 1;
    localparam int    VEC_NMI     = 2;
    localparam int    VEC_HARD    = 3;
    localparam int    VEC_SYNC_HI = 13;
    localparam int    VEC_FIXED   = 3;
    localparam int    VEC_EXT0    = 16;
endpackage

// File: rtl/prio_nest_scan.sv
module prio_nest_scan
    import prio_nest_pkg::*;
#(
    parameter int NUM_VEC = 24,
    parameter int VW      = 5
) (
    input  logic [NUM_VEC-1:0]            en,
    input  logic [NUM_VEC-1:0]            pend,
    input  logic [NUM_VEC-1:0]            act,
    input  logic [NUM_VEC-1:0][9:0]       prio,
    output logic [VW-1:0]                 win_idx,
    output prio_t                         win_prio,
    output prio_t                         act_min,
    output logic                          act_multi
);
    logic [VW:0] act_cnt;

    always_comb begin
        win_idx  = '0;
        win_prio = PRIO_NONE;
        act_min  = PRIO_NONE;
        act_cnt  = '0;
        for (int i = 1; i < NUM_VEC; i++) begin
            if (en[i] && pend[i] && ($signed(prio[i]) < win_prio)) begin
                win_prio = $signed(prio[i]);
                win_idx  = VW'(i);
            end
            if (act[i]) begin
                act_cnt = act_cnt + 1'b1;
                if ($signed(prio[i]) < act_min) begin
                    act_min = $signed(prio[i]);
                end
            end
        end
        act_multi = (act_cnt >= 2);
    end
endmodule

// File: rtl/prio_nest_exec.sv
module prio_nest_exec
    import prio_nest_pkg::*;
(
    input  logic [2:0] grp,
    input  logic       fmask,
    input  logic       imask,
    input  logic [7:0] basepri,
    input  prio_t      act_min,
    output prio_t      act_grp,
    output prio_t      exec_prio
);
    prio_t mask;
    prio_t running;

    always_comb begin
        mask    = $signed(10'h3FF << (4'(grp) + 4'd1));
        act_grp = act_min & mask;
        if (fmask) begin
            running = -10'sd1;
        end else if (imask) begin
            running = 10'sd0;
        end else if (basepri != 8'd0) begin
            running = $signed({2'b00, basepri}) & mask;
        end else begin
            running = PRIO_NONE;
        end
        exec_prio = (running < act_grp) ? running : act_grp;
    end
endmodule

// File: rtl/prio_nest_arb.sv
module prio_nest_arb
    import prio_nest_pkg::*;
#(
    parameter int NUM_EXT = 8,
    parameter int NUM_VEC = VEC_EXT0 + NUM_EXT,
    parameter int VW      = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] irq_level_i,
    input  logic [NUM_VEC-1:0] pend_set_i,
    input  logic [NUM_VEC-1:0] pend_clr_i,
    input  logic [NUM_VEC-1:0] en_set_i,
    input  logic [NUM_VEC-1:0] en_clr_i,
    input  logic               prio_we_i,
    input  logic [VW-1:0]      prio_idx_i,
    input  logic [7:0]         prio_val_i,
    input  logic [2:0]         grp_i,
    input  logic               fmask_i,
    input  logic               imask_i,
    input  logic [7:0]         basepri_i,
    input  logic               ack_i,
    input  logic               done_i,
    input  logic [VW-1:0]      done_idx_i,
    output logic [VW-1:0]      pend_vec_o,
    output logic               take_o,
    output logic               can_take_o,
    output logic               ret_base_o,
    output logic               done_err_o,
    output logic               forced_o,
    output logic               lockup_o
);
    localparam int LAST_VEC = NUM_VEC - 1;

    typedef struct packed {
        logic [NUM_VEC-1:0]      en;
        logic [NUM_VEC-1:0]      pend;
        logic [NUM_VEC-1:0]      act;
        logic [NUM_VEC-1:0][9:0] prio;
        logic [NUM_EXT-1:0]      lvl;
        logic [VW-1:0]           pv;
        logic                    take;
        logic                    can;
        logic                    rb;
        logic                    err;
        logic                    forced;
        logic                    lock;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [VW-1:0] win_idx;
    prio_t         win_prio;
    prio_t         act_min;
    logic          act_multi;
    prio_t         act_grp;
    prio_t         exec_prio;

    prio_nest_scan #(.NUM_VEC(NUM_VEC), .VW(VW)) u_scan (
        .en        (st_q.en),
        .pend      (st_q.pend),
        .act       (st_q.act),
        .prio      (st_q.prio),
        .win_idx   (win_idx),
        .win_prio  (win_prio),
        .act_min   (act_min),
        .act_multi (act_multi)
    );

    prio_nest_exec u_exec (
        .grp       (grp_i),
        .fmask     (fmask_i),
        .imask     (imask_i),
        .basepri   (basepri_i),
        .act_min   (act_min),
        .act_grp   (act_grp),
        .exec_prio (exec_prio)
    );

    // reset value of the state register
    function automatic arb_state_t reset_state();
        arb_state_t r;
        r = '0;
        r.en[VEC_NMI]  = 1'b1;
        r.en[VEC_HARD] = 1'b1;
        r.en[11]       = 1'b1;
        r.en[12]       = 1'b1;
        r.en[14]       = 1'b1;
        r.en[15]       = 1'b1;
        r.prio[VEC_RESET] = 10'h3FD;
        r.prio[VEC_NMI]   = 10'h3FE;
        r.prio[VEC_HARD]  = 10'h3FF;
        return r;
    endfunction

    logic idx_ok;
    logic done_ok;
    logic hard_req;
    logic lock_req;
    logic blocked;
    int   ext_no;

    always_comb begin
        st_d     = st_q;
        hard_req = 1'b0;
        lock_req = 1'b0;
        blocked  = 1'b0;
        ext_no   = 0;

        // enables of configurable vectors
        for (int i = VEC_FIXED + 1; i < NUM_VEC; i++) begin
            st_d.en[i] = en_set_i[i] | (st_q.en[i] & ~en_clr_i[i]);
        end

        // priority write, fixed vectors protected
        idx_ok = (int'(prio_idx_i) > VEC_FIXED) && (int'(prio_idx_i) <= LAST_VEC);
        if (prio_we_i && idx_ok) begin
            st_d.prio[prio_idx_i] = {2'b00, prio_val_i};
        end

        // pending: clear first, then every kind of set
        st_d.pend = st_q.pend & ~pend_clr_i;
        for (int i = VEC_NMI; i < NUM_VEC; i++) begin
            if (pend_set_i[i]) begin
                if (i >= VEC_HARD && i <= VEC_SYNC_HI) begin
                    blocked = ($signed(st_q.prio[i]) >= exec_prio) || !st_q.en[i];
                    if (!blocked) begin
                        st_d.pend[i] = 1'b1;
                    end else if (exec_prio < 0) begin
                        lock_req = 1'b1;
                    end else begin
                        hard_req = 1'b1;
                    end
                end else begin
                    st_d.pend[i] = 1'b1;
                end
            end
        end
        if (hard_req) begin
            st_d.pend[VEC_HARD] = 1'b1;
        end
        st_d.forced = st_q.forced | hard_req;
        st_d.lock   = st_q.lock | lock_req;

        // external level lines: rising edge pends
        for (int e = 0; e < NUM_EXT; e++) begin
            if (irq_level_i[e] && !st_q.lvl[e]) begin
                st_d.pend[VEC_EXT0 + e] = 1'b1;
            end
        end
        st_d.lvl = irq_level_i;

        // completion: result flags and re-pend of a held level
        done_ok = 1'b0;
        st_d.rb  = 1'b0;
        st_d.err = 1'b0;
        if (done_i) begin
            if (int'(done_idx_i) <= LAST_VEC && st_q.act[done_idx_i]) begin
                done_ok = 1'b1;
                st_d.rb = !act_multi;
                if (int'(done_idx_i) >= VEC_EXT0) begin
                    ext_no = int'(done_idx_i) - VEC_EXT0;
                    if (irq_level_i[ext_no]) begin
                        st_d.pend[done_idx_i] = 1'b1;
                    end
                end
            end else begin
                st_d.err = 1'b1;
            end
        end

        // acknowledge of the registered winner
        if (ack_i && (st_q.pv != '0) && st_q.pend[st_q.pv]) begin
            st_d.pend[st_q.pv] = 1'b0;
            st_d.act[st_q.pv]  = 1'b1;
        end
        if (done_ok) begin
            st_d.act[done_idx_i] = 1'b0;
        end

        st_d.pend[0] = 1'b0;
        st_d.pend[VEC_RESET] = 1'b0;

        // registered decisions from the stored state
        st_d.pv   = win_idx;
        st_d.take = (win_prio < act_grp);
        st_d.can  = (exec_prio > win_prio);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= reset_state();
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_vec_o = st_q.pv;
    assign take_o     = st_q.take;
    assign can_take_o = st_q.can;
    assign ret_base_o = st_q.rb;
    assign done_err_o = st_q.err;
    assign forced_o   = st_q.forced;
    assign lockup_o   = st_q.lock;
endmodule

// File: rtl/prio_nest_arb_chk.sv
module prio_nest_arb_chk #(
    parameter int VW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fmask_i,
    input logic          done_i,
    input logic [VW-1:0] pend_vec_o,
    input logic          take_o,
    input logic          can_take_o,
    input logic          ret_base_o,
    input logic          done_err_o,
    input logic          forced_o,
    input logic          lockup_o
);
    // R6
    lockup_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lockup_o |=> lockup_o);

    // R5
    forced_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        forced_o |=> forced_o);

    // R8
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ret_base_o && done_err_o));

    // R8
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_base_o || done_err_o) |-> $past(done_i));

    // R2
    no_reset_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vec_o != VW'(1));

    // R3
    take_has_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (pend_vec_o != '0));

    // R4
    fmask_only_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (can_take_o && $past(fmask_i)) |-> (pend_vec_o == VW'(2)));
endmodule

bind prio_nest_arb prio_nest_arb_chk #(.VW(VW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmask_i    (fmask_i),
    .done_i     (done_i),
    .pend_vec_o (pend_vec_o),
    .take_o     (take_o),
    .can_take_o (can_take_o),
    .ret_base_o (ret_base_o),
    .done_err_o (done_err_o),
    .forced_o   (forced_o),
    .lockup_o   (lockup_o)
);

// File: tb/prio_nest_arb_test.sv
module prio_nest_arb_test;
    localparam int NE = 8;
    localparam int NV = 16 + NE;
    localparam int VW = $clog2(NV);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] lvl = '0;
    logic [NV-1:0] pset = '0, pclr = '0, eset = '0, eclr = '0;
    logic          pwe = 1'b0;
    logic [VW-1:0] pidx = '0;
    logic [7:0]    pval = '0;
    logic [2:0]    grp = '0;
    logic          fm = 1'b0, im = 1'b0;
    logic [7:0]    bp = '0;
    logic          ack = 1'b0, done = 1'b0;
    logic [VW-1:0] didx = '0;

    logic [VW-1:0] pv;
    logic take, can, rb, err, forced, lock;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    prio_nest_arb #(.NUM_EXT(NE)) uut (
        .clk(clk), .rst_n(rst_n), .irq_level_i(lvl),
        .pend_set_i(pset), .pend_clr_i(pclr), .en_set_i(eset), .en_clr_i(eclr),
        .prio_we_i(pwe), .prio_idx_i(pidx), .prio_val_i(pval),
        .grp_i(grp), .fmask_i(fm), .imask_i(im), .basepri_i(bp),
        .ack_i(ack), .done_i(done), .done_idx_i(didx),
        .pend_vec_o(pv), .take_o(take), .can_take_o(can),
        .ret_base_o(rb), .done_err_o(err), .forced_o(forced), .lockup_o(lock)
    );

    // behavioural reference model
    int mp[NV];
    bit men[NV], mpd[NV], mac[NV];
    bit mlv[NE];
    int e_pv;
    bit e_take, e_can, e_rb, e_err, e_forced, e_lock;

    always @(posedge clk) begin : model
        int wi, wp, am, na, gm, ag, run, ex, hv, v;
        bit hreq, nen[NV], npd[NV], nac[NV];
        if (!rst_n) begin
            for (int i = 0; i < NV; i++) begin
                mp[i] = 0; men[i] = 0; mpd[i] = 0; mac[i] = 0;
            end
            mp[1] = -3; mp[2] = -2; mp[3] = -1;
            men[2] = 1; men[3] = 1; men[11] = 1; men[12] = 1; men[14] = 1; men[15] = 1;
            for (int e = 0; e < NE; e++) mlv[e] = 0;
            e_pv = 0; e_take = 0; e_can = 0; e_rb = 0; e_err = 0; e_forced = 0; e_lock = 0;
        end else begin
            wi = 0; wp = 256; am = 256; na = 0;
            for (int i = 1; i < NV; i++) begin
                if (men[i] && mpd[i] && mp[i] < wp) begin wp = mp[i]; wi = i; end
                if (mac[i]) begin na++; if (mp[i] < am) am = mp[i]; end
            end
            gm = -1 << (int'(grp) + 1);
            ag = am & gm;
            if (fm) run = -1;
            else if (im) run = 0;
            else if (bp != 0) run = int'(bp) & gm;
            else run = 256;
            ex = (run < ag) ? run : ag;
            for (int i = 0; i < NV; i++) begin nen[i] = men[i]; npd[i] = mpd[i] && !pclr[i]; nac[i] = mac[i]; end
            for (int i = 4; i < NV; i++) if (eset[i]) nen[i] = 1; else if (eclr[i]) nen[i] = 0;
            hreq = 0;
            for (int i = 2; i < NV; i++) begin
                if (pset[i]) begin
                    if (i >= 3 && i <= 13 && (mp[i] >= ex || !men[i])) begin
                        if (ex < 0) e_lock = 1; else hreq = 1;
                    end else npd[i] = 1;
                end
            end
            if (hreq) begin npd[3] = 1; e_forced = 1; end
            for (int e = 0; e < NE; e++) begin
                if (lvl[e] && !mlv[e]) npd[16 + e] = 1;
                mlv[e] = lvl[e];
            end
            e_rb = 0; e_err = 0; hv = int'(didx);
            if (done) begin
                if (hv < NV && mac[hv]) begin
                    e_rb = (na < 2);
                    if (hv >= 16 && lvl[hv - 16]) npd[hv] = 1;
                end else e_err = 1;
            end
            v = e_pv;
            if (ack && v != 0 && mpd[v]) begin npd[v] = 0; nac[v] = 1; end
            if (done && hv < NV && mac[hv]) nac[hv] = 0;
            if (pwe && int'(pidx) > 3 && int'(pidx) < NV) mp[pidx] = int'(pval);
            npd[0] = 0; npd[1] = 0;
            for (int i = 0; i < NV; i++) begin men[i] = nen[i]; mpd[i] = npd[i]; mac[i] = nac[i]; end
            e_pv = wi; e_take = (wp < ag); e_can = (ex > wp);
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // per-cycle comparison with the model (R11 timing)
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R11", "pend_vec_o model", int'(pv), e_pv);
            chk("R11", "flags model",
                {take, can, rb, err, forced, lock},
                {e_take, e_can, e_rb, e_err, e_forced, e_lock});
        end
    end

    task automatic cyc(); @(negedge clk); endtask
    task automatic idle();
        pset = '0; pclr = '0; eset = '0; eclr = '0; pwe = 1'b0; ack = 1'b0; done = 1'b0;
    endtask
    task automatic wprio(int idx, int val);
        pwe = 1'b1; pidx = VW'(idx); pval = 8'(val); cyc(); idle();
    endtask
    task automatic doneq(int idx);
        done = 1'b1; didx = VW'(idx); cyc(); idle();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1
        chk("R1", "pend_vec_o", int'(pv), 0);
        chk("R1", "outputs", {take, can, rb, err, forced, lock}, 0);

        // R2 / R11
        wprio(16, 8'h40); wprio(17, 8'h20);
        eset[16] = 1; eset[17] = 1; cyc(); idle();
        pset[16] = 1; cyc(); idle();
        chk("R11", "lag before update", int'(pv), 0);
        cyc();
        chk("R2", "single pending", int'(pv), 16);
        chk("R3", "take idle core", int'(take), 1);
        pset[17] = 1; cyc(); idle(); cyc();
        chk("R2", "lower prio wins", int'(pv), 17);
        wprio(17, 8'h40); cyc();
        chk("R2", "tie lower number", int'(pv), 16);

        // R7 / R3
        ack = 1; cyc(); idle(); cyc();
        chk("R7", "acked left pending", int'(pv), 17);
        chk("R3", "equal prio no take", int'(take), 0);
        wprio(17, 8'h30); cyc();
        chk("R3", "take grp0", int'(take), 1);
        grp = 3'd7; cyc(); cyc();
        chk("R3", "take grp7", int'(take), 0);
        grp = 3'd0; cyc(); cyc();

        // R4
        chk("R4", "can no mask", int'(can), 1);
        im = 1; cyc();
        chk("R4", "can imask", int'(can), 0);
        im = 0; bp = 8'h20; cyc();
        chk("R4", "can basepri 0x20", int'(can), 0);
        bp = 8'h38; cyc();
        chk("R4", "can basepri 0x38", int'(can), 1);
        bp = 8'h00; cyc();

        // R8
        ack = 1; cyc(); idle(); cyc();
        doneq(17);
        chk("R8", "ret_base two active", int'(rb), 0);
        doneq(16);
        chk("R8", "ret_base last", int'(rb), 1);
        doneq(16);
        chk("R8", "error inactive", int'(err), 1);
        chk("R8", "no ret_base on error", int'(rb), 0);

        // R9
        wprio(18, 8'h10); eset[18] = 1; cyc(); idle();
        lvl[2] = 1'b1; cyc(); cyc();
        chk("R9", "rising edge pends", int'(pv), 18);
        ack = 1; cyc(); idle(); cyc();
        chk("R9", "acked", int'(pv), 0);
        cyc(); cyc();
        chk("R9", "held level no pend", int'(pv), 0);
        doneq(18);
        chk("R9", "ret_base", int'(rb), 1);
        cyc();
        chk("R9", "repend on done", int'(pv), 18);
        pclr[18] = 1; lvl[2] = 1'b0; cyc(); idle(); cyc();
        chk("R12", "clear strobe", int'(pv), 0);

        // R5
        pset[4] = 1; cyc(); idle();
        chk("R5", "forced flag", int'(forced), 1);
        cyc();
        chk("R5", "disabled to hard", int'(pv), 3);
        pclr[3] = 1; cyc(); idle(); cyc();
        eset[4] = 1; pwe = 1; pidx = VW'(4); pval = 8'h10; cyc(); idle();
        pset[4] = 1; cyc(); idle(); cyc();
        chk("R5", "enabled not escalated", int'(pv), 4);
        pclr[4] = 1; cyc(); idle();
        wprio(4, 8'h80); bp = 8'h40;
        pset[4] = 1; cyc(); idle(); cyc();
        chk("R5", "blocked to hard", int'(pv), 3);
        pclr[3] = 1; bp = 8'h00; cyc(); idle(); cyc();

        // R6
        fm = 1; pset[4] = 1; cyc(); idle();
        chk("R6", "lockup", int'(lock), 1);
        cyc();
        chk("R6", "nothing pended", int'(pv), 0);
        fm = 0; cyc();

        // R10
        wprio(2, 8'hFF); wprio(16, 8'h00);
        pset[2] = 1; pset[16] = 1; cyc(); idle(); cyc();
        chk("R10", "nmi keeps fixed prio", int'(pv), 2);
        pclr[2] = 1; pclr[16] = 1; cyc(); idle(); cyc();
        chk("R12", "both cleared", int'(pv), 0);

        // R12
        pset[16] = 1; pclr[16] = 1; cyc(); idle(); cyc();
        chk("R12", "set wins over clear", int'(pv), 16);
        cyc(); cyc();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule